// File: doc/BRIEF.md
# Cascaded Prescaler Timer with One-Shot Compares

The block is a free-running 32-bit timer built from two chained counter stages. The first stage is a reloading prescaler. It advances once every second system clock, counts up to a programmable period, wraps to zero and flips a square-wave line each time it wraps. The second stage is the main counter. It samples that line in the system clock domain and adds one on every rising edge, so it ticks at half the wrap rate of the prescaler. To get a main tick frequency f from a core clock F, software programs a period of about F / 4 / f.

Three compare channels watch the main counter. Each channel has its own compare value, interrupt enable and status flag. A channel fires when an increment lands the counter on its compare value while it is enabled. Firing latches the status flag and clears the channel's enable, so each armed compare produces one interrupt. Writing a compare value arms that channel. Enables can also be set and cleared through separate write-one-to-set and write-one-to-clear addresses. Reading the status register returns the flags and clears them. The interrupt line is raised while any flag is pending, and a selector output names the lowest pending channel, so that channels are serviced in the order A, B, C.

A small register interface, with single-cycle writes and combinational reads, covers the period, the compare values, the enable masks, the status, the counter readback and the start and stop commands.

Top module: `cascade_timer`

## Requirements
- R1: After reset the main counter, period, compare values, enables and status are zero, the prescaler is stopped, the toggle line is low and irq is low. The counter holds at zero until a start command is given.
- R2: The control register is at word address 9. Writing bit 0 (start) resets the prescaler count and its clock phase, drives the line low and sets the prescaler running. Writing bit 1 (stop) halts it. When both bits are written together, the stop wins and the prescaler ends up stopped with its count reset.
- R3: While running, the prescaler advances on every second clock edge and wraps to zero on the advance where its count is equal to or greater than the period P. Each wrap flips tick_line, so n edges after the start edge tick_line equals (n / (2(P+1))) mod 2.
- R4: The main counter adds one on the clock edge that follows each rising edge of tick_line. Counting from the start edge, it has gained 0 when n < 2(P+1)+1 and 1 + (n − 2(P+1) − 1) / (4(P+1)) otherwise. A start command does not clear it.
- R5: Once the prescaler is stopped, the main counter stays frozen.
- R6: The word address map is: 0 period, 1, 2 and 3 compare A, B and C, 4 enable-set, 5 enable-clear, 6 enable readback, 7 status, 8 counter, 9 control. Reads of any other address, or of write-only addresses, return zero.
- R7: The enable and status bits 0, 1 and 2 belong to compares A, B and C. Writing a compare value sets that channel's enable. A 1 written to enable-set sets the matching enable, and a 1 written to enable-clear clears it.
- R8: An enabled compare fires when an increment makes the counter equal its compare value. Firing sets its status bit and clears its enable in the same edge. Several channels holding the same value fire together.
- R9: A compare whose enable is clear never sets its status bit.
- R10: A read of address 7 returns the status bits and clears them. A bit that fires on the same edge as that read is kept, and the next read returns it.
- R11: irq is high while any status bit is set. irq_sel gives the index of the lowest set status bit (A=0, B=1, C=2) and is 0 when none is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of the status register clears it |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Pending compare interrupt |
| irq_sel | output | 2 | Index of the lowest pending compare |
| tick_line | output | 1 | Prescaler square-wave line |

## Verification
The delicate coincidence is a status read that lands on the same clock edge as a compare firing. The bench works out from the start edge the exact edge of the first increment and asserts the status read across that edge. It expects that read to return zero, irq to rise straight after it, and a second read to return the kept flag. A second coincidence places compares B and C on the same counter value. The bench then expects both flags in one read, both enables cleared, and irq_sel pointing at B.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
    localparam int ADDR_W = 4;
    localparam int NCMP   = 3;
    localparam int SEL_W  = 2;

    localparam logic [ADDR_W-1:0] A_PERIOD = 4'd0;
    localparam logic [ADDR_W-1:0] A_CMP_A  = 4'd1;
    localparam logic [ADDR_W-1:0] A_IEN_S  = 4'd4;
    localparam logic [ADDR_W-1:0] A_IEN_C  = 4'd5;
    localparam logic [ADDR_W-1:0] A_IEN_R  = 4'd6;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'd7;
    localparam logic [ADDR_W-1:0] A_COUNT  = 4'd8;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd9;

    localparam int CTRL_START = 0;
    localparam int CTRL_STOP  = 1;
endpackage

// File: rtl/ctm_prescaler.sv
module ctm_prescaler #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [PER_W-1:0] period,
    output logic             run,
    output logic             line
);
    typedef struct packed {
        logic             run;
        logic             ph;
        logic [PER_W-1:0] cnt;
        logic             line;
    } pre_t;

    pre_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.run) begin
            s_d.ph = ~s_q.ph;
            if (s_q.ph) begin
                if (s_q.cnt >= period) begin
                    s_d.cnt  = '0;
                    s_d.line = ~s_q.line;
                end else begin
                    s_d.cnt = s_q.cnt + PER_W'(1);
                end
            end
        end
        if (start) begin
            s_d.run  = 1'b1;
            s_d.ph   = 1'b0;
            s_d.cnt  = '0;
            s_d.line = 1'b0;
        end
        if (stop) begin
            s_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run  = s_q.run;
    assign line = s_q.line;
endmodule

// File: rtl/ctm_main_cnt.sv
module ctm_main_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line,
    output logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_inc
);
    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } main_t;

    main_t s_d, s_q;
    logic  rise;

    assign rise    = line & ~s_q.prev;
    assign cnt_inc = s_q.cnt + CNT_W'(1);

    always_comb begin
        s_d      = s_q;
        s_d.prev = line;
        if (rise) s_d.cnt = cnt_inc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick = rise;
    assign cnt  = s_q.cnt;
endmodule

// File: rtl/ctm_cmp_bank.sv
module ctm_cmp_bank #(
    parameter int CNT_W = 32,
    parameter int NCMP  = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCMP-1:0]            cmp_we,
    input  logic [CNT_W-1:0]           wdata,
    input  logic [NCMP-1:0]            ien_set,
    input  logic [NCMP-1:0]            ien_clr,
    input  logic                       stat_rd,
    input  logic                       tick,
    input  logic [CNT_W-1:0]           cnt_inc,
    output logic [NCMP-1:0][CNT_W-1:0] cmp,
    output logic [NCMP-1:0]            ien,
    output logic [NCMP-1:0]            stat
);
    typedef struct packed {
        logic [NCMP-1:0][CNT_W-1:0] cmp;
        logic [NCMP-1:0]            ien;
        logic [NCMP-1:0]            stat;
    } bank_t;

    bank_t           s_d, s_q;
    logic [NCMP-1:0] fire;

    for (genvar i = 0; i < NCMP; i++) begin : g_fire
        assign fire[i] = tick && s_q.ien[i] && (cnt_inc == s_q.cmp[i]);
    end

    always_comb begin
        s_d      = s_q;
        s_d.ien  = (s_q.ien | ien_set | cmp_we) & ~ien_clr & ~fire;
        s_d.stat = (stat_rd ? '0 : s_q.stat) | fire;
        for (int i = 0; i < NCMP; i++) begin
            if (cmp_we[i]) s_d.cmp[i] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cmp  = s_q.cmp;
    assign ien  = s_q.ien;
    assign stat = s_q.stat;
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
    import ctm_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PER_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq,
    output logic [SEL_W-1:0]  irq_sel,
    output logic              tick_line
);
    typedef struct packed {
        logic [PER_W-1:0] period;
    } top_t;

    top_t                       s_d, s_q;
    logic                       start_w, stop_w, run_w, line_w, tick_w, stat_rd;
    logic [CNT_W-1:0]           cnt_w, cnt_inc_w;
    logic [NCMP-1:0]            cmp_we, ien_set, ien_clr, ien_w, stat_w;
    logic [NCMP-1:0][CNT_W-1:0] cmp_w;

    assign start_w = reg_wr && (reg_addr == A_CTRL) && reg_wdata[CTRL_START];
    assign stop_w  = reg_wr && (reg_addr == A_CTRL) && reg_wdata[CTRL_STOP];
    assign stat_rd = reg_rd && (reg_addr == A_STAT);
    assign ien_set = (reg_wr && reg_addr == A_IEN_S) ? reg_wdata[NCMP-1:0] : '0;
    assign ien_clr = (reg_wr && reg_addr == A_IEN_C) ? reg_wdata[NCMP-1:0] : '0;

    for (genvar i = 0; i < NCMP; i++) begin : g_we
        localparam logic [ADDR_W-1:0] CADDR = A_CMP_A + ADDR_W'(i);
        assign cmp_we[i] = reg_wr && (reg_addr == CADDR);
    end

    always_comb begin
        s_d = s_q;
        if (reg_wr && reg_addr == A_PERIOD) s_d.period = reg_wdata[PER_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    ctm_prescaler #(.PER_W(PER_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .start(start_w), .stop(stop_w),
        .period(s_q.period), .run(run_w), .line(line_w)
    );

    ctm_main_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .line(line_w),
        .tick(tick_w), .cnt(cnt_w), .cnt_inc(cnt_inc_w)
    );

    ctm_cmp_bank #(.CNT_W(CNT_W), .NCMP(NCMP)) u_bank (
        .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we), .wdata(reg_wdata),
        .ien_set(ien_set), .ien_clr(ien_clr), .stat_rd(stat_rd),
        .tick(tick_w), .cnt_inc(cnt_inc_w),
        .cmp(cmp_w), .ien(ien_w), .stat(stat_w)
    );

    always_comb begin
        irq_sel = '0;
        for (int i = NCMP - 1; i >= 0; i--) begin
            if (stat_w[i]) irq_sel = SEL_W'(i);
        end
    end

    assign irq       = |stat_w;
    assign tick_line = line_w;

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                A_PERIOD: reg_rdata = CNT_W'(s_q.period);
                A_IEN_R:  reg_rdata = CNT_W'(ien_w);
                A_STAT:   reg_rdata = CNT_W'(stat_w);
                A_COUNT:  reg_rdata = cnt_w;
                default: begin
                    for (int i = 0; i < NCMP; i++) begin
                        if (reg_addr == A_CMP_A + ADDR_W'(i)) reg_rdata = cmp_w[i];
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/ctm_checker.sv
module ctm_checker #(
    parameter int CNT_W = 32,
    parameter int NCMP  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             start,
    input logic             line,
    input logic [CNT_W-1:0] cnt,
    input logic [NCMP-1:0]  stat,
    input logic [NCMP-1:0]  ien,
    input logic             irq,
    input logic [1:0]       irq_sel
);
    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

    p_frozen_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run)) |=> $stable(cnt));

    p_line_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> $stable(line));

    p_one_shot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(stat)) & ien) == '0);

    p_fire_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(stat)) & ~$past(ien)) == '0);

    p_irq_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ien) != '0);

    p_sel_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sel < 2'd3);
endmodule

bind cascade_timer ctm_checker #(.CNT_W(CNT_W), .NCMP(3)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run_w), .start(start_w), .line(line_w),
    .cnt(cnt_w), .stat(stat_w), .ien(ien_w), .irq(irq), .irq_sel(irq_sel)
);

// File: tb/cascade_timer_tb.sv
module cascade_timer_tb;
    localparam logic [3:0] PERIOD = 4'd0, CMPA = 4'd1, CMPB = 4'd2, CMPC = 4'd3;
    localparam logic [3:0] IENS = 4'd4, IENC = 4'd5, IENR = 4'd6, STAT = 4'd7;
    localparam logic [3:0] COUNT = 4'd8, CTRL = 4'd9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, tick_line;
    logic [1:0]  irq_sel;

    int checks = 0, errors = 0, cyc = 0, start_cyc = 0;

    cascade_timer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .irq_sel(irq_sel), .tick_line(tick_line)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic wait_n(input int t);
        while (cyc - start_cyc < t) @(negedge clk);
    endtask

    function automatic int exp_cnt(input int n, input int p);
        if (n < 2 * (p + 1) + 1) return 0;
        return 1 + (n - 2 * (p + 1) - 1) / (4 * (p + 1));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, c0, c1;
        int n;
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", 32'(irq), 0);
        chk("R1 line", 32'(tick_line), 0);
        rd(COUNT, v);  chk("R1 count", v, 0);
        rd(STAT, v);   chk("R1 status", v, 0);
        rd(IENR, v);   chk("R1 enables", v, 0);
        rd(PERIOD, v); chk("R1 period", v, 0);
        rd(CMPC, v);   chk("R1 compare", v, 0);
        idle(10);
        rd(COUNT, v);  chk("R1 held without start", v, 0);
        rd(4'd12, v);  chk("R6 unmapped", v, 0);

        // R3/R4 sweep over small periods
        for (int p = 0; p < 4; p++) begin
            wr(CTRL, 32'h2);
            idle(6);
            rd(COUNT, c0);
            wr(PERIOD, 32'(p));
            rd(PERIOD, v); chk("R6 period readback", v, 32'(p));
            wr(CTRL, 32'h1);
            start_cyc = cyc;
            for (int s = 0; s < 24 * (p + 1); s++) begin
                n = cyc - start_cyc;
                chk("R3 line", 32'(tick_line), 32'((n / (2 * (p + 1))) % 2));
                rd(COUNT, v);
                chk("R4 count", v, c0 + 32'(exp_cnt(n, p)));
            end
        end

        // R2 start and stop together: stop wins; R5 frozen
        wr(CTRL, 32'h3);
        idle(4);
        rd(COUNT, c0);
        idle(30);
        rd(COUNT, c1);
        chk("R2 stop wins / R5 frozen", c1, c0);
        chk("R2 line low", 32'(tick_line), 0);
        idle(30);
        rd(COUNT, c1);
        chk("R5 still frozen", c1, c0);

        // Compare behaviour with period 0
        wr(PERIOD, 32'h0);
        wr(CMPA, c0 + 1);
        wr(CMPB, c0 + 2);
        wr(CMPC, c0 + 2);
        rd(IENR, v); chk("R7 arm by compare write", v, 32'h7);
        rd(CMPB, v); chk("R6 compare readback", v, c0 + 2);
        wr(CTRL, 32'h1);
        start_cyc = cyc;
        wait_n(2);
        chk("R11 no irq before fire", 32'(irq), 0);
        rd(STAT, v); chk("R10 read on fire edge", v, 0);
        chk("R11 irq after A fires", 32'(irq), 1);
        chk("R11 sel A", 32'(irq_sel), 0);
        rd(IENR, v); chk("R8 A enable cleared", v, 32'h6);
        rd(STAT, v); chk("R10 kept flag returned", v, 32'h1);
        chk("R10 irq cleared by read", 32'(irq), 0);
        wait_n(8);
        chk("R11 irq B and C", 32'(irq), 1);
        chk("R11 sel lowest is B", 32'(irq_sel), 1);
        rd(STAT, v); chk("R8 B and C together", v, 32'h6);
        rd(IENR, v); chk("R8 all one-shot cleared", v, 0);
        chk("R11 sel none", 32'(irq_sel), 0);

        // R9 disabled compare, R7 set/clear masks
        rd(COUNT, c1);
        wr(CMPA, c1 + 3);
        wr(IENC, 32'h1);
        rd(IENR, v); chk("R7 clear mask", v, 0);
        wr(CMPB, c1 + 3);
        wr(IENS, 32'h4);
        rd(IENR, v); chk("R7 set mask", v, 32'h6);
        idle(40);
        chk("R11 sel B only", 32'(irq_sel), 1);
        rd(STAT, v); chk("R9 disabled A silent", v, 32'h2);
        rd(IENR, v); chk("R8 C still armed", v, 32'h4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule